// File: doc/BRIEF.md
# Reverse Channel Frame Builder with Manchester Line Coder

This block produces the serial transmit stream of one reverse-channel message. A start strobe launches a frame made of four fields, always in this order. First comes a preamble of alternating bits. Then an 11-bit synchronization pattern, then a 7-bit expansion of a 2-bit colour code, and last a chosen number of 48-bit code words. The code-word bits come from an external parity encoder through a one-bit request handshake. The block only sequences these bits; it computes no parity.

Each frame bit is sent on a single line as a Manchester symbol of two equal halves. Every half lasts a fixed, parameterised number of clock cycles, and the bit timing stays continuous across field boundaries. The colour code and the word count are captured when the frame starts. When the last half-bit ends, the line returns to its idle level and a one-cycle completion flag is raised.

Top module: `rcf_frame_tx`

## Requirements
- R1: After reset and between frames, `line_o` is 0 and both `done_o` and `cw_req_o` are 0.
- R2: A frame opens with `DOT_LEN` preamble bits (default 30) that alternate, the first being 1.
- R3: Right after the preamble, the 11-bit pattern 11100010010 is sent, leftmost bit first.
- R4: Next come 7 colour bits, leftmost first, taken from `cc_i` as sampled at start: 00 gives 0000000, 01 gives 0011111, 10 gives 1100011 and 11 gives 1111100. Changes to `cc_i` during a frame have no effect.
- R5: Next come `nwords_i` times 48 code-word bits, with `nwords_i` sampled at start. For each such bit, `cw_req_o` is high for exactly one cycle and `cw_bit_i` is taken in that same cycle. When `nwords_i` is 0 the frame ends after the colour bits.
- R6: A data 1 is sent as a low half followed by a high half, and a data 0 as a high half followed by a low half. Each half lasts exactly `HALF_CYCLES` clock cycles, counted from the edge that accepts the start strobe.
- R7: `done_o` is high for exactly one cycle, in the cycle that follows the final half-bit. From that cycle on, `line_o` is at its idle level of 0.
- R8: A start strobe that arrives while a frame is in progress is ignored. The frame content and its length are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; it launches a frame when the block is idle |
| cc_i | input | 2 | Colour code, sampled at start |
| nwords_i | input | NW_W | Number of 48-bit code words, sampled at start |
| cw_bit_i | input | 1 | Code-word bit from the parity encoder, taken while `cw_req_o` is high |
| cw_req_o | output | 1 | Requests the next code-word bit |
| line_o | output | 1 | Manchester-coded line output |
| done_o | output | 1 | One-cycle pulse when the frame has finished |

## Verification
The hardest situation to reach is a second start strobe that falls in the middle of a code word. In that same frame, the colour-code and word-count inputs also change after the frame has begun. Only a frame whose length and content both stay intact shows that all three were ignored. To get there, the disturbing scenario drives a new strobe, a new colour code and a new word count at a fixed cycle deep inside the code-word field of a three-word frame. It then compares every half-bit and the timing of the completion flag against the values predicted from the inputs sampled at start.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
    localparam int SYNC_BITS = 11;
    localparam int CC_BITS   = 7;
    localparam int CW_BITS   = 48;
    localparam logic [SYNC_BITS-1:0] SYNC_WORD = 11'b11100010010;

    typedef enum logic [1:0] {
        FLD_DOT  = 2'd0,
        FLD_SYNC = 2'd1,
        FLD_CC   = 2'd2,
        FLD_CW   = 2'd3
    } field_e;

    // Expand the two-bit colour code to its seven-bit transmitted form.
    function automatic logic [CC_BITS-1:0] cc_expand(input logic [1:0] cc);
        logic [CC_BITS-1:0] w;
        case (cc)
            2'b00:   w = 7'b0000000;
            2'b01:   w = 7'b0011111;
            2'b10:   w = 7'b1100011;
            default: w = 7'b1111100;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/rcf_halfbit_timer.sv
module rcf_halfbit_timer #(
    parameter int HALF_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    output logic half_o,
    output logic bit_end_o
);
    localparam int DIV_W = (HALF_CYCLES > 2) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYCLES - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             half;
    } tmr_t;

    tmr_t st_d, st_q;
    logic tick;

    always_comb begin
        st_d = st_q;
        tick = run_i && (st_q.div == DIV_LAST);
        if (restart_i) begin
            st_d.div  = '0;
            st_d.half = 1'b0;
        end else if (run_i) begin
            if (tick) begin
                st_d.div  = '0;
                st_d.half = ~st_q.half;
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign half_o    = st_q.half;
    assign bit_end_o = tick && st_q.half;
endmodule

// File: rtl/rcf_field_seq.sv
module rcf_field_seq
    import rcf_pkg::*;
#(
    parameter int DOT_LEN = 30,
    parameter int NW_W    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      cc_i,
    input  logic [NW_W-1:0] nwords_i,
    input  logic            cw_bit_i,
    input  logic            bit_end_i,
    output logic            start_ok_o,
    output logic            busy_o,
    output logic            bit_o,
    output logic            cw_req_o,
    output logic            done_o
);
    localparam int IDX_MAX = (DOT_LEN > CW_BITS) ? DOT_LEN : CW_BITS;
    localparam int IDX_W   = $clog2(IDX_MAX);
    localparam logic [IDX_W-1:0] DOT_LAST  = IDX_W'(DOT_LEN - 1);
    localparam logic [IDX_W-1:0] SYNC_LAST = IDX_W'(SYNC_BITS - 1);
    localparam logic [IDX_W-1:0] CC_LAST   = IDX_W'(CC_BITS - 1);
    localparam logic [IDX_W-1:0] CW_LAST   = IDX_W'(CW_BITS - 1);

    typedef struct packed {
        logic                 busy;
        field_e               field;
        logic [IDX_W-1:0]     idx;
        logic [NW_W-1:0]      wleft;
        logic [SYNC_BITS-1:0] sh;
        logic [1:0]           cc;
        logic                 bit_v;
        logic                 done;
    } seq_t;

    seq_t st_d, st_q;
    logic start_ok;
    logic req;

    assign start_ok = start_i && !st_q.busy;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        req       = 1'b0;
        if (start_ok) begin
            st_d.busy  = 1'b1;
            st_d.field = FLD_DOT;
            st_d.idx   = '0;
            st_d.wleft = nwords_i;
            st_d.cc    = cc_i;
            st_d.sh    = '0;
            st_d.bit_v = 1'b1;
        end else if (st_q.busy && bit_end_i) begin
            st_d.idx = st_q.idx + 1'b1;
            unique case (st_q.field)
                FLD_DOT: begin
                    if (st_q.idx == DOT_LAST) begin
                        st_d.field = FLD_SYNC;
                        st_d.idx   = '0;
                        st_d.sh    = SYNC_WORD;
                        st_d.bit_v = SYNC_WORD[SYNC_BITS-1];
                    end else begin
                        st_d.bit_v = ~st_q.bit_v;
                    end
                end
                FLD_SYNC: begin
                    if (st_q.idx == SYNC_LAST) begin
                        st_d.field = FLD_CC;
                        st_d.idx   = '0;
                        st_d.sh    = {cc_expand(st_q.cc), {(SYNC_BITS-CC_BITS){1'b0}}};
                        st_d.bit_v = st_d.sh[SYNC_BITS-1];
                    end else begin
                        st_d.sh    = st_q.sh << 1;
                        st_d.bit_v = st_q.sh[SYNC_BITS-2];
                    end
                end
                FLD_CC: begin
                    if (st_q.idx == CC_LAST) begin
                        if (st_q.wleft == '0) begin
                            st_d.busy = 1'b0;
                            st_d.done = 1'b1;
                        end else begin
                            st_d.field = FLD_CW;
                            st_d.idx   = '0;
                            req        = 1'b1;
                            st_d.bit_v = cw_bit_i;
                        end
                    end else begin
                        st_d.sh    = st_q.sh << 1;
                        st_d.bit_v = st_q.sh[SYNC_BITS-2];
                    end
                end
                default: begin
                    if (st_q.idx == CW_LAST) begin
                        if (st_q.wleft == NW_W'(1)) begin
                            st_d.busy = 1'b0;
                            st_d.done = 1'b1;
                        end else begin
                            st_d.wleft = st_q.wleft - 1'b1;
                            st_d.idx   = '0;
                            req        = 1'b1;
                            st_d.bit_v = cw_bit_i;
                        end
                    end else begin
                        req        = 1'b1;
                        st_d.bit_v = cw_bit_i;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.field <= FLD_DOT;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_ok_o = start_ok;
    assign busy_o     = st_q.busy;
    assign bit_o      = st_q.bit_v;
    assign cw_req_o   = req;
    assign done_o     = st_q.done;
endmodule

// File: rtl/rcf_manchester_enc.sv
module rcf_manchester_enc #(
    parameter logic IDLE_LEVEL = 1'b0
) (
    input  logic busy_i,
    input  logic half_i,
    input  logic bit_i,
    output logic line_o
);
    // A one is low then high; a zero is high then low.
    always_comb begin
        if (!busy_i)     line_o = IDLE_LEVEL;
        else if (half_i) line_o = bit_i;
        else             line_o = ~bit_i;
    end
endmodule

// File: rtl/rcf_frame_tx.sv
module rcf_frame_tx #(
    parameter int DOT_LEN     = 30,
    parameter int HALF_CYCLES = 4,
    parameter int NW_W        = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      cc_i,
    input  logic [NW_W-1:0] nwords_i,
    input  logic            cw_bit_i,
    output logic            cw_req_o,
    output logic            line_o,
    output logic            done_o
);
    logic start_ok_w;
    logic busy_w;
    logic half_w;
    logic bit_end_w;
    logic bit_w;

    rcf_halfbit_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (start_ok_w),
        .run_i     (busy_w),
        .half_o    (half_w),
        .bit_end_o (bit_end_w)
    );

    rcf_field_seq #(.DOT_LEN(DOT_LEN), .NW_W(NW_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cc_i       (cc_i),
        .nwords_i   (nwords_i),
        .cw_bit_i   (cw_bit_i),
        .bit_end_i  (bit_end_w),
        .start_ok_o (start_ok_w),
        .busy_o     (busy_w),
        .bit_o      (bit_w),
        .cw_req_o   (cw_req_o),
        .done_o     (done_o)
    );

    rcf_manchester_enc #(.IDLE_LEVEL(1'b0)) u_enc (
        .busy_i (busy_w),
        .half_i (half_w),
        .bit_i  (bit_w),
        .line_o (line_o)
    );
endmodule

// File: rtl/rcf_frame_tx_chk.sv
module rcf_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic line_o,
    input logic done_o,
    input logic cw_req_o,
    input logic busy,
    input logic half
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy && $past(busy))); // R7
    AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !line_o); // R1
    AST_REQ_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        cw_req_o |-> busy); // R5
    AST_MID_BIT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $rose(half)) |-> (line_o != $past(line_o))); // R6
    AST_START_IN_FRAME_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i && !done_o) |=> (busy || done_o)); // R8
endmodule

bind rcf_frame_tx rcf_frame_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .line_o   (line_o),
    .done_o   (done_o),
    .cw_req_o (cw_req_o),
    .busy     (busy_w),
    .half     (half_w)
);

// File: tb/rcf_frame_tx_tb.sv
`timescale 1ns/1ps
module rcf_frame_tx_tb;
    localparam int DOT_LEN = 30;
    localparam int HC      = 4;
    localparam int NW_W    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [1:0] cc_i = 2'b00;
    logic [NW_W-1:0] nwords_i = '0;
    logic cw_bit_i;
    logic cw_req_o, line_o, done_o;

    int checks = 0;
    int fails = 0;
    int ptr = 0;
    int req_seen = 0;

    always #5 clk = ~clk;

    rcf_frame_tx #(.DOT_LEN(DOT_LEN), .HALF_CYCLES(HC), .NW_W(NW_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cc_i(cc_i),
        .nwords_i(nwords_i), .cw_bit_i(cw_bit_i), .cw_req_o(cw_req_o),
        .line_o(line_o), .done_o(done_o)
    );

    function automatic logic pat(input int p);
        int v = p * 13 + (p >> 2) + 3;
        return v[0] ^ v[3];
    endfunction

    assign cw_bit_i = pat(ptr);

    always @(posedge clk) begin
        if (cw_req_o) begin
            ptr      <= ptr + 1;
            req_seen <= req_seen + 1;
        end
    end

    function automatic logic [6:0] cc_tab(input logic [1:0] c);
        case (c)
            2'b00: return 7'b0000000;
            2'b01: return 7'b0011111;
            2'b10: return 7'b1100011;
            default: return 7'b1111100;
        endcase
    endfunction

    function automatic logic exp_bit(input int k, input logic [1:0] c);
        logic [10:0] sw = 11'b11100010010;
        logic [6:0]  cw = cc_tab(c);
        if (k < DOT_LEN)           return (k % 2 == 0);
        if (k < DOT_LEN + 11)      return sw[10 - (k - DOT_LEN)];
        if (k < DOT_LEN + 18)      return cw[6 - (k - DOT_LEN - 11)];
        return pat(k - DOT_LEN - 18);
    endfunction

    function automatic string tag_of(input int k);
        if (k < DOT_LEN)      return "R2";
        if (k < DOT_LEN + 11) return "R3";
        if (k < DOT_LEN + 18) return "R4";
        return "R5";
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", line_o, 1'b0, "line after reset");
        chk("R1", done_o, 1'b0, "done after reset");
        chk("R1", cw_req_o, 1'b0, "req after reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", line_o, 1'b0, "line idle before start");
    endtask

    // One frame; when disturb is set, a second start, a new colour code and a new word count arrive mid-frame.
    task automatic t_frame(input logic [1:0] c, input int n, input bit disturb);
        int total = DOT_LEN + 18 + 48 * n;
        int span  = total * 2 * HC;
        @(negedge clk);
        ptr      = 0;
        req_seen = 0;
        cc_i     = c;
        nwords_i = NW_W'(n);
        start_i  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        for (int j = 0; j <= span + 1; j++) begin
            if (j < span) begin
                int k = j / (2 * HC);
                int p = j % (2 * HC);
                logic b = exp_bit(k, c);
                if (p == 0 || p == HC - 1)
                    chk(tag_of(k), line_o, ~b, $sformatf("first half bit %0d", k));
                if (p == HC || p == 2 * HC - 1)
                    chk("R6", line_o, b, $sformatf("second half bit %0d", k));
                if (p == 1) chk("R7", done_o, 1'b0, "done early");
            end else if (j == span) begin
                chk("R7", done_o, 1'b1, "done at frame end");
                chk("R7", line_o, 1'b0, "line idle at end");
            end else begin
                chk("R7", done_o, 1'b0, "done width");
                chk("R1", line_o, 1'b0, "line idle after frame");
                chk("R1", cw_req_o, 1'b0, "req idle after frame");
            end
            if (disturb && j == span - 200) begin
                start_i  = 1'b1;
                cc_i     = ~c;
                nwords_i = NW_W'(n + 2);
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        chk_int("R5", req_seen, 48 * n, "code-word requests");
        if (disturb) chk_int("R8", req_seen, 48 * n, "frame unchanged by mid-frame start");
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_frame(2'b00, 1, 1'b0);
        t_frame(2'b01, 1, 1'b0);
        t_frame(2'b10, 0, 1'b0);
        t_frame(2'b11, 2, 1'b0);
        t_frame(2'b01, 3, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule